// File: doc/BRIEF.md
# Counter / Feedback Stream Mode Unit

This unit turns an external, encryption-only block cipher core into a stream cipher. It holds a chaining state register, sends that state to the core, and XORs the keystream that comes back with the incoming data block to produce the outgoing block. The same datapath is used to encrypt and to decrypt. Only the forward direction of the core is ever called. In decryption the data input carries ciphertext and the data output carries plaintext. In encryption the roles are reversed.

Two chaining rules can be selected. In counter mode the state starts at the initialization vector and steps up by one after every block. It wraps modulo 2^W. In feedback mode the state is replaced after every block by that block's ciphertext. The ciphertext is the output block when encrypting and the input block when decrypting. An IV load strobe writes the state and samples the mode and direction together. The unit processes one block at a time. Input and output use a valid/ready handshake, and the core is reached through a start/done pair.

Top module: `stream_mode_unit`

## Requirements
- R1: Every output block equals the accepted input block XORed with the keystream that the core returns for that block.
- R2: In counter mode (mode_sel = 0 at load) the state sent to the core for the first block equals the loaded IV, and it grows by one for each later block.
- R3: In counter mode the state wraps from all ones to all zeros with no other effect.
- R4: In feedback mode (mode_sel = 1 at load) the state for each later block is the previous ciphertext. That is the previous output block when decrypt = 0 and the previous input block when decrypt = 1. An encrypt/decrypt pass from the same IV therefore returns the original data.
- R5: For each accepted block core_start is high for exactly one cycle. The state offered on core_state stays unchanged while the core is busy. Both directions use the same forward core.
- R6: in_ready is low from the cycle after a block is accepted until the cycle after its output is taken.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_block holds its value.
- R8: iv_load takes effect only while the unit is idle. When it arrives during a block it is ignored, and in_ready is low in any cycle where iv_load is high.
- R9: mode_sel and decrypt are sampled only on an accepted IV load. Changing them at any other time has no effect on later blocks.
- R10: After reset out_valid and core_start are low and in_ready is high. The state is zero, in counter mode, encrypting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iv_load | input | 1 | Load strobe for IV, mode and direction |
| iv_value | input | W | Initialization vector |
| mode_sel | input | 1 | 0 = counter, 1 = ciphertext feedback |
| decrypt | input | 1 | 1 = decrypt, 0 = encrypt |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Unit can accept a block |
| in_block | input | W | Plaintext (encrypt) or ciphertext (decrypt) |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Consumer takes the output block |
| out_block | output | W | Ciphertext (encrypt) or plaintext (decrypt) |
| core_start | output | 1 | One-cycle request to the cipher core |
| core_state | output | W | Chaining state given to the core |
| core_done | input | 1 | Core result valid |
| core_keystream | input | W | Core output for core_state |

## Verification
The bench builds the unit with W = 32, which is narrow enough to load an IV of all ones and cross the counter wrap within two blocks. It also keeps the keyed stand-in core cheap to restate in the bench. The core model answers after three cycles. This leaves room to pulse iv_load and to flip mode_sel and decrypt while a block is waiting. Holding out_ready low for two cycles exercises output backpressure.

// File: rtl/strm_pkg.sv
package strm_pkg;
  typedef enum logic {MODE_CTR = 1'b0, MODE_CFB = 1'b1} mode_e;
  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT, PH_HOLD} phase_e;
endpackage

// File: rtl/strm_ctrl.sv
module strm_ctrl
  import strm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic iv_load,
  input  logic in_valid,
  input  logic core_done,
  input  logic out_ready,
  output logic in_ready,
  output logic core_start,
  output logic out_valid,
  output logic ev_accept,
  output logic ev_done,
  output logic ev_load,
  output logic busy
);
  phase_e ph_q, ph_d;

  logic idle;
  assign idle       = (ph_q == PH_IDLE);
  assign busy       = !idle;
  assign ev_load    = idle && iv_load;
  assign in_ready   = idle && !iv_load;
  assign ev_accept  = in_valid && in_ready;
  assign core_start = (ph_q == PH_ISSUE);
  assign ev_done    = (ph_q == PH_WAIT) && core_done;
  assign out_valid  = (ph_q == PH_HOLD);

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (ev_accept) ph_d = PH_ISSUE;
      PH_ISSUE: ph_d = PH_WAIT;
      PH_WAIT:  if (core_done) ph_d = PH_HOLD;
      PH_HOLD:  if (out_ready) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/strm_mix.sv
module strm_mix #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_accept,
  input  logic         ev_done,
  input  logic [W-1:0] in_block,
  input  logic [W-1:0] keystream,
  output logic [W-1:0] blk_in,
  output logic [W-1:0] mix_out,
  output logic [W-1:0] out_q
);
  function automatic logic [W-1:0] combine(input logic [W-1:0] data,
                                           input logic [W-1:0] ks);
    return data ^ ks;
  endfunction

  assign mix_out = combine(blk_in, keystream);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_in <= '0;
      out_q  <= '0;
    end else begin
      if (ev_accept) blk_in <= in_block;
      if (ev_done)   out_q  <= mix_out;
    end
  end
endmodule

// File: rtl/strm_chain.sv
module strm_chain
  import strm_pkg::*;
#(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_load,
  input  logic         ev_done,
  input  logic [W-1:0] iv_value,
  input  logic         mode_sel,
  input  logic         decrypt,
  input  logic [W-1:0] blk_in,
  input  logic [W-1:0] mix_out,
  output logic [W-1:0] state_q,
  output mode_e        mode_q,
  output logic         dec_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] ctr_step(input logic [W-1:0] s);
    return s + ONE;
  endfunction

  function automatic logic [W-1:0] fb_pick(input logic dec,
                                           input logic [W-1:0] din,
                                           input logic [W-1:0] dout);
    return dec ? din : dout;
  endfunction

  logic [W-1:0] next_state;
  assign next_state = (mode_q == MODE_CFB) ? fb_pick(dec_q, blk_in, mix_out)
                                           : ctr_step(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      mode_q  <= MODE_CTR;
      dec_q   <= 1'b0;
    end else if (ev_load) begin
      state_q <= iv_value;
      mode_q  <= mode_e'(mode_sel);
      dec_q   <= decrypt;
    end else if (ev_done) begin
      state_q <= next_state;
    end
  end
endmodule

// File: rtl/stream_mode_unit.sv
module stream_mode_unit
  import strm_pkg::*;
#(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         iv_load,
  input  logic [W-1:0] iv_value,
  input  logic         mode_sel,
  input  logic         decrypt,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_block,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_block,
  output logic         core_start,
  output logic [W-1:0] core_state,
  input  logic         core_done,
  input  logic [W-1:0] core_keystream
);
  logic         ev_accept, ev_done, ev_load, busy;
  logic [W-1:0] blk_in, mix_out;
  mode_e        mode_q;
  logic         dec_q;

  strm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .iv_load    (iv_load),
    .in_valid   (in_valid),
    .core_done  (core_done),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .core_start (core_start),
    .out_valid  (out_valid),
    .ev_accept  (ev_accept),
    .ev_done    (ev_done),
    .ev_load    (ev_load),
    .busy       (busy)
  );

  strm_mix #(.W(W)) u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_accept (ev_accept),
    .ev_done   (ev_done),
    .in_block  (in_block),
    .keystream (core_keystream),
    .blk_in    (blk_in),
    .mix_out   (mix_out),
    .out_q     (out_block)
  );

  strm_chain #(.W(W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_load  (ev_load),
    .ev_done  (ev_done),
    .iv_value (iv_value),
    .mode_sel (mode_sel),
    .decrypt  (decrypt),
    .blk_in   (blk_in),
    .mix_out  (mix_out),
    .state_q  (core_state),
    .mode_q   (mode_q),
    .dec_q    (dec_q)
  );
endmodule

// File: rtl/strm_unit_chk.sv
module strm_unit_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_block,
  input logic         core_start,
  input logic [W-1:0] core_state,
  input logic [W-1:0] core_keystream,
  input logic         ev_done,
  input logic         busy,
  input logic [W-1:0] blk_in,
  input logic         mode_cfb,
  input logic         dec_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  p_mix_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> out_block == ($past(blk_in) ^ $past(core_keystream)));

  p_ctr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && !mode_cfb |=> core_state == $past(core_state) + ONE);

  p_ctr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && !mode_cfb && (&core_state) |=> core_state == '0);

  p_fb_enc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && mode_cfb && !dec_q |=> core_state == out_block);

  p_fb_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && mode_cfb && dec_q |=> core_state == $past(blk_in));

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  p_one_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_block));

  p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ev_done |=> $stable(core_state) && $stable(mode_cfb) && $stable(dec_q));
endmodule

bind stream_mode_unit strm_unit_chk #(.W(W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_block      (out_block),
  .core_start     (core_start),
  .core_state     (core_state),
  .core_keystream (core_keystream),
  .ev_done        (ev_done),
  .busy           (busy),
  .blk_in         (blk_in),
  .mode_cfb       (mode_q == strm_pkg::MODE_CFB),
  .dec_q          (dec_q)
);

// File: tb/sim_stream_mode_unit.sv
module sim_stream_mode_unit;
  localparam int W   = 32;
  localparam int LAT = 3;
  localparam logic [W-1:0] KEY = 32'h6B3D_A1C7;

  typedef struct packed {
    logic         m;
    logic         d;
    logic [W-1:0] iv;
    logic [W-1:0] b0;
    logic [W-1:0] b1;
    logic [W-1:0] b2;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 1'b0, 32'h0000_1000, 32'h1111_2222, 32'h3333_4444, 32'h5555_6666},
    '{1'b0, 1'b1, 32'h8000_00FF, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hCAFE_0001},
    '{1'b1, 1'b0, 32'h1234_5678, 32'hA5A5_5A5A, 32'h0F0F_F0F0, 32'h0000_0000},
    '{1'b1, 1'b1, 32'h9ABC_DEF0, 32'h7777_1234, 32'hFFFF_0000, 32'h0102_0304}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iv_load = 1'b0, mode_sel = 1'b0, decrypt = 1'b0;
  logic [W-1:0] iv_value = '0, in_block = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, core_start;
  logic [W-1:0] out_block, core_state;
  logic core_done = 1'b0;
  logic [W-1:0] core_keystream = '0;

  always #10 clk = ~clk;

  stream_mode_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .iv_load(iv_load), .iv_value(iv_value),
    .mode_sel(mode_sel), .decrypt(decrypt), .in_valid(in_valid),
    .in_ready(in_ready), .in_block(in_block), .out_valid(out_valid),
    .out_ready(out_ready), .out_block(out_block), .core_start(core_start),
    .core_state(core_state), .core_done(core_done),
    .core_keystream(core_keystream)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int starts = 0;
  int blocks = 0;
  int cnt = 0;
  logic [W-1:0] held_state = '0;
  logic [W-1:0] seen_state = '0;

  function automatic logic [W-1:0] kf(input logic [W-1:0] x);
    return {x[W-6:0], x[W-1:W-5]} ^ KEY;
  endfunction

  // stand-in cipher core: answers LAT cycles after a start
  always @(negedge clk) begin
    core_done = 1'b0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        core_done = 1'b1;
        core_keystream = kf(held_state);
      end
    end
    if (core_start) begin
      held_state = core_state;
      seen_state = core_state;
      starts = starts + 1;
      cnt = LAT;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic m, input logic d, input logic [W-1:0] iv);
    @(negedge clk);
    iv_load = 1'b1; iv_value = iv; mode_sel = m; decrypt = d;
    #1;
    chk(in_ready == 1'b0, "R8 in_ready low during load", {31'b0, in_ready}, '0);
    @(negedge clk);
    iv_load = 1'b0;
  endtask

  task automatic run_block(input logic [W-1:0] din, input int hold, input bit poke,
                           output logic [W-1:0] dout, output logic [W-1:0] st);
    logic [W-1:0] keep;
    @(negedge clk);
    in_valid = 1'b1; in_block = din;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R6 in_ready low after accept", {31'b0, in_ready}, '0);
    if (poke) begin
      iv_load = 1'b1; iv_value = ~din; mode_sel = ~mode_sel; decrypt = ~decrypt;
      @(negedge clk);
      iv_load = 1'b0;
    end
    while (!out_valid) @(negedge clk);
    for (int h = 0; h < hold; h++) begin
      keep = out_block;
      @(negedge clk);
      chk(out_valid && out_block == keep, "R7 output held", out_block, keep);
      chk(!in_ready, "R6 in_ready low while output pending", {31'b0, in_ready}, '0);
    end
    dout = out_block;
    st = seen_state;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    blocks = blocks + 1;
  endtask

  initial begin
    logic [W-1:0] dout, st, rs, din, expv;
    logic [W-1:0] c0, c1;

    #1;
    chk(out_valid == 1'b0 && core_start == 1'b0 && in_ready == 1'b1,
        "R10 reset outputs", {29'b0, out_valid, core_start, in_ready}, 32'h1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 idle after reset",
        {30'b0, out_valid, in_ready}, 32'h1);

    // R10: state zero, counter mode, encrypt without any load
    run_block(32'h4242_4242, 0, 1'b0, dout, st);
    chk(st == '0, "R10 reset state", st, '0);
    chk(dout == (32'h4242_4242 ^ kf('0)), "R10 R1 reset mode output", dout, 32'h4242_4242 ^ kf('0));

    // vector table walk
    for (int v = 0; v < 4; v++) begin
      load(VECS[v].m, VECS[v].d, VECS[v].iv);
      rs = VECS[v].iv;
      for (int k = 0; k < 3; k++) begin
        din = (k == 0) ? VECS[v].b0 : (k == 1) ? VECS[v].b1 : VECS[v].b2;
        run_block(din, (k == 1) ? 2 : 0, 1'b0, dout, st);
        expv = din ^ kf(rs);
        chk(st == rs, VECS[v].m ? "R4 feedback state" : "R2 counter state", st, rs);
        chk(dout == expv, "R1 output block", dout, expv);
        if (VECS[v].m) rs = VECS[v].d ? din : expv;
        else           rs = rs + 1;
      end
    end

    // R3 counter wrap
    load(1'b0, 1'b0, 32'hFFFF_FFFF);
    run_block(32'h0000_0001, 0, 1'b0, dout, st);
    chk(st == 32'hFFFF_FFFF, "R3 pre-wrap state", st, 32'hFFFF_FFFF);
    run_block(32'h0000_0002, 0, 1'b0, dout, st);
    chk(st == '0, "R3 wrapped state", st, '0);
    chk(dout == (32'h0000_0002 ^ kf('0)), "R3 R1 wrapped output", dout, 32'h0000_0002 ^ kf('0));

    // R4 round trip
    load(1'b1, 1'b0, 32'h0C0F_FEE0);
    run_block(32'h1357_9BDF, 0, 1'b0, c0, st);
    run_block(32'h2468_ACE0, 0, 1'b0, c1, st);
    load(1'b1, 1'b1, 32'h0C0F_FEE0);
    run_block(c0, 0, 1'b0, dout, st);
    chk(dout == 32'h1357_9BDF, "R4 round trip block 0", dout, 32'h1357_9BDF);
    run_block(c1, 0, 1'b0, dout, st);
    chk(dout == 32'h2468_ACE0, "R4 round trip block 1", dout, 32'h2468_ACE0);

    // R8 R9: load attempt and mode flips while busy are ignored
    load(1'b0, 1'b0, 32'h0000_0100);
    run_block(32'hAAAA_0000, 0, 1'b1, dout, st);
    chk(st == 32'h0000_0100, "R8 state during busy load", st, 32'h0000_0100);
    run_block(32'hBBBB_0000, 0, 1'b0, dout, st);
    chk(st == 32'h0000_0101, "R8 R9 state after ignored load", st, 32'h0000_0101);
    chk(dout == (32'hBBBB_0000 ^ kf(32'h0000_0101)), "R9 counter mode kept",
        dout, 32'hBBBB_0000 ^ kf(32'h0000_0101));

    // R9: direction flip between blocks without load
    load(1'b1, 1'b0, 32'h5050_5050);
    run_block(32'h0000_FFFF, 0, 1'b0, c0, st);
    decrypt = 1'b1;
    run_block(32'h1111_1111, 0, 1'b0, dout, st);
    chk(st == c0, "R9 feedback still uses output", st, c0);

    // R5 one start per block
    chk(starts == blocks, "R5 one core start per block", starts, blocks);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule